// File: doc/BRIEF.md
# Smart Card Character Receiver

This block takes characters from the half-duplex I/O line of a smart card and places them in a small receive queue. Each character is framed by one start bit, eight data bits and one parity bit, followed by one guard time. The line is sampled once per elementary time unit, on a strobe that an external baud generator places in the middle of each bit. Software picks one of two bit conventions. Direct convention sends the least significant bit first, and a high line means logic 1. Inverse convention sends the most significant bit first, and a low line means logic 1. Under inverse convention the parity bit is read inverted as well.

Each stored character carries its own parity-error flag next to its data byte. A read interrupt asserts while the number of queued characters is above a programmable tide level. The usual sequence at answer-to-reset is as follows. Software leaves the block in direct convention with even parity and tide 0. It reads the initial character, which is 0x3B for a direct card. If the card is inverse, its initial character decodes as 0x3F under inverse convention, and software then sets the convention bit for the rest of the session.

Top module: `sc_char_rx`

## Requirements
- R1: After a synchronous reset, fifo_level is 0 and rx_irq is 0.
- R2: When conv_inv is 0 (direct), line bits after the start bit map to data bits 0 to 7 in that order, and a high line is a 1.
- R3: When conv_inv is 1 (inverse), line bits after the start bit map to data bits 7 down to 0, a low line is a 1, and the parity bit is inverted. In this convention the line pattern of the inverse initial character decodes to 0x3F.
- R4: When parity_odd is 0, the parity check is even: the XOR of the eight data bits and the decoded parity bit must be 0. Otherwise rd_perr is 1 for that character.
- R5: When parity_odd is 1, the XOR of the eight data bits and the decoded parity bit must be 1. Otherwise rd_perr is 1.
- R6: Characters leave in the order they arrived. rd_data and rd_perr show the oldest entry. A pulse on rd_pop removes that entry and lowers fifo_level by one.
- R7: rd_pop while fifo_level is 0 has no effect.
- R8: The queue holds 8 characters. A character that completes while the queue is full and no pop is made is dropped, and the 8 stored characters are unchanged.
- R9: rx_irq is 1 exactly when fifo_level is greater than tide_lvl (0 to 7). With tide 0, one stored character raises it.
- R10: A frame starts only on a strobe that sees the line low while idle. Strobes with a high line while idle are ignored. The strobe after the parity bit is the guard time and its line value is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| io_line | input | 1 | Card I/O line (asynchronous) |
| etu_stb | input | 1 | One-cycle mid-bit sample strobe, one per etu |
| conv_inv | input | 1 | 0 direct, 1 inverse convention |
| parity_odd | input | 1 | 0 even parity, 1 odd parity |
| tide_lvl | input | 3 | Interrupt tide level |
| rd_pop | input | 1 | Remove oldest character |
| rd_data | output | 8 | Oldest character byte |
| rd_perr | output | 1 | Parity error flag of oldest character |
| fifo_level | output | 4 | Characters stored, 0 to 8 |
| rx_irq | output | 1 | Read interrupt |

## Verification
The assertions check the queue bookkeeping on every cycle. This covers the level after reset, that the level never goes above the depth, a one-step rise on each accepted push, no change when popping an empty queue, holding at full, and that the interrupt is low while the queue is empty. The bench scenarios are needed to show the decoding itself: bit order and polarity in each convention, parity under both settings, the order in which data comes out, dropping at overflow, and ignoring idle strobes with a high line.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;
    localparam int CHAR_W    = 8;
    localparam int FRAME_W   = CHAR_W + 1;
    localparam int CNT_W     = $clog2(FRAME_W);

    typedef struct packed {
        logic              perr;
        logic [CHAR_W-1:0] data;
    } rx_char_t;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_BITS  = 2'd1,
        FR_GUARD = 2'd2
    } frame_state_t;

    // raw[0] is the first line bit after start, raw[CHAR_W] is parity
    function automatic rx_char_t decode_char(
        input logic [FRAME_W-1:0] raw,
        input logic               inverse,
        input logic               odd
    );
        rx_char_t c;
        logic     par;
        for (int i = 0; i < CHAR_W; i++) begin
            if (inverse) c.data[CHAR_W-1-i] = ~raw[i];
            else         c.data[i]          = raw[i];
        end
        par    = inverse ? ~raw[CHAR_W] : raw[CHAR_W];
        c.perr = ((^c.data) ^ par) != odd;
        return c;
    endfunction
endpackage

// File: rtl/sc_rx_sync.sv
module sc_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/sc_rx_framer.sv
module sc_rx_framer
    import sc_rx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               line,
    input  logic               stb,
    output logic [FRAME_W-1:0] raw,
    output logic               done
);
    frame_state_t     state;
    logic [CNT_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FR_IDLE;
            idx   <= '0;
            raw   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (stb) begin
                unique case (state)
                    FR_IDLE: begin
                        if (!line) begin
                            state <= FR_BITS;
                            idx   <= '0;
                        end
                    end
                    FR_BITS: begin
                        raw[idx] <= line;
                        if (idx == CNT_W'(FRAME_W - 1)) begin
                            state <= FR_GUARD;
                            done  <= 1'b1;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                    FR_GUARD: state <= FR_IDLE;
                    default:  state <= FR_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/sc_rx_fifo.sv
module sc_rx_fifo
    import sc_rx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  rx_char_t         wr_char,
    input  logic             pop,
    output rx_char_t         head,
    output logic [LVL_W-1:0] level
);
    rx_char_t         mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic             pop_ok, push_ok;

    assign pop_ok  = pop && (level != '0);
    assign push_ok = push && ((level != LVL_W'(DEPTH)) || pop_ok);
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= wr_char;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (push_ok) wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop_ok)  rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
            unique case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/sc_char_rx.sv
module sc_char_rx
    import sc_rx_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int TIDE_W = 3,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_line,
    input  logic              etu_stb,
    input  logic              conv_inv,
    input  logic              parity_odd,
    input  logic [TIDE_W-1:0] tide_lvl,
    input  logic              rd_pop,
    output logic [CHAR_W-1:0] rd_data,
    output logic              rd_perr,
    output logic [LVL_W-1:0]  fifo_level,
    output logic              rx_irq
);
    logic               line_s;
    logic [FRAME_W-1:0] raw;
    logic               char_push;
    rx_char_t           dec, head;

    sc_rx_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .din(io_line), .dout(line_s)
    );

    sc_rx_framer u_framer (
        .clk(clk), .rst(rst), .line(line_s), .stb(etu_stb),
        .raw(raw), .done(char_push)
    );

    assign dec = decode_char(raw, conv_inv, parity_odd);

    sc_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(char_push), .wr_char(dec),
        .pop(rd_pop), .head(head), .level(fifo_level)
    );

    assign rd_data = head.data;
    assign rd_perr = head.perr;
    assign rx_irq  = fifo_level > LVL_W'(tide_lvl);
endmodule

// File: rtl/sc_char_rx_chk.sv
module sc_char_rx_chk #(
    parameter int DEPTH = 8,
    parameter int LVL_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             push,
    input logic             pop,
    input logic [LVL_W-1:0] level,
    input logic             irq
);
    // R1
    reset_level_chk: assert property (@(posedge clk) rst |=> (level == '0 && !irq));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_W'(DEPTH));

    // R6
    push_step_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && level < LVL_W'(DEPTH)) |=> level == $past(level) + 1'b1);

    // R7
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && level == '0) |=> level == '0);

    // R8
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (level == LVL_W'(DEPTH) && !pop) |=> level == LVL_W'(DEPTH));

    // R9
    empty_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (level == '0) |-> !irq);
endmodule

bind sc_char_rx sc_char_rx_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst(rst), .push(char_push), .pop(rd_pop),
    .level(fifo_level), .irq(rx_irq)
);

// File: tb/sc_char_rx_tb.sv
module sc_char_rx_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       io_line = 1'b1;
    logic       etu_stb = 1'b0;
    logic       conv_inv = 1'b0;
    logic       parity_odd = 1'b0;
    logic [2:0] tide_lvl = 3'd0;
    logic       rd_pop = 1'b0;
    logic [7:0] rd_data;
    logic       rd_perr;
    logic [3:0] fifo_level;
    logic       rx_irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sc_char_rx u_dut (
        .clk(clk), .rst(rst), .io_line(io_line), .etu_stb(etu_stb),
        .conv_inv(conv_inv), .parity_odd(parity_odd), .tide_lvl(tide_lvl),
        .rd_pop(rd_pop), .rd_data(rd_data), .rd_perr(rd_perr),
        .fifo_level(fifo_level), .rx_irq(rx_irq)
    );

    // {conv_inv, parity_odd, bad_parity, tide[2:0], byte[7:0]}
    localparam int NVEC = 8;
    localparam logic [13:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 3'd0, 8'h3B},
        {1'b1, 1'b0, 1'b0, 3'd0, 8'h3F},
        {1'b0, 1'b0, 1'b1, 3'd0, 8'hA5},
        {1'b1, 1'b0, 1'b1, 3'd0, 8'h5A},
        {1'b0, 1'b1, 1'b0, 3'd0, 8'h00},
        {1'b1, 1'b1, 1'b1, 3'd0, 8'hFF},
        {1'b0, 1'b0, 1'b0, 3'd1, 8'h81},
        {1'b1, 1'b1, 1'b0, 3'd0, 8'h1E}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic etu(input logic lvl);
        io_line = lvl;
        repeat (3) @(posedge clk);
        #1 etu_stb = 1'b1;
        @(posedge clk);
        #1 etu_stb = 1'b0;
    endtask

    // drives a frame; bad flips the parity bit
    task automatic send(input logic [7:0] b, input logic inv, input logic odd, input logic bad);
        logic p;
        p = (^b) ^ odd ^ bad;
        etu(1'b0);
        for (int i = 0; i < 8; i++) etu(inv ? ~b[7-i] : b[i]);
        etu(inv ? ~p : p);
        etu(1'b1);
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pop1();
        @(negedge clk) rd_pop = 1'b1;
        @(negedge clk) rd_pop = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        check("R1 level", 32'(fifo_level), 0);
        check("R1 irq", 32'(rx_irq), 0);

        // table walk: R2 R3 R4 R5 R9
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] b;
            b          = VEC[v][7:0];
            conv_inv   = VEC[v][13];
            parity_odd = VEC[v][12];
            tide_lvl   = VEC[v][10:8];
            send(b, VEC[v][13], VEC[v][12], VEC[v][11]);
            check(VEC[v][13] ? "R3 data" : "R2 data", 32'(rd_data), 32'(b));
            check(VEC[v][12] ? "R5 perr" : "R4 perr", 32'(rd_perr), 32'(VEC[v][11]));
            check("R6 level", 32'(fifo_level), 1);
            check("R9 irq", 32'(rx_irq), 32'(VEC[v][10:8] == 3'd0));
            pop1();
            check("R6 pop", 32'(fifo_level), 0);
        end

        // R7: pop while empty
        conv_inv = 1'b0; parity_odd = 1'b0; tide_lvl = 3'd0;
        pop1(); pop1();
        check("R7 level", 32'(fifo_level), 0);
        send(8'h42, 1'b0, 1'b0, 1'b0);
        check("R7 data after empty pop", 32'(rd_data), 32'h42);
        check("R7 level", 32'(fifo_level), 1);
        pop1();

        // R10: idle strobes with high line ignored
        etu(1'b1); etu(1'b1); etu(1'b1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 idle", 32'(fifo_level), 0);
        send(8'hC3, 1'b0, 1'b0, 1'b0);
        check("R10 data", 32'(rd_data), 32'hC3);
        pop1();

        // R8 / R6 / R9: fill past depth, tide 7
        tide_lvl = 3'd7;
        for (int k = 0; k < 9; k++) begin
            send(8'(8'h10 + k), 1'b0, 1'b0, 1'b0);
            if (k == 6) check("R9 level7 tide7", 32'(rx_irq), 0);
        end
        check("R8 level", 32'(fifo_level), 8);
        check("R9 irq full", 32'(rx_irq), 1);
        for (int k = 0; k < 8; k++) begin
            check("R6 order", 32'(rd_data), 32'(8'h10 + k));
            pop1();
        end
        check("R8 dropped", 32'(fifo_level), 0);

        // R1 again: reset mid-content
        send(8'h77, 1'b0, 1'b0, 1'b0);
        do_reset();
        check("R1 level after reset", 32'(fifo_level), 0);
        check("R1 irq after reset", 32'(rx_irq), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule